// File: doc/BRIEF.md
# Gigabit Copper Transmit Test Pattern Sequencer

This block supplies the symbol stream for a transmitter characterisation test mode of a four-pair gigabit copper PHY. It issues one symbol per clock at the 125 MHz symbol rate. Every symbol is a signed five-level value, and the same value appears on all four lanes at once. The analog line drivers that follow the block turn each symbol into a voltage. This block only decides which symbol comes next.

One period lasts 1792 symbols and has three parts. The first part is four isolated impulses, of values +2, -2, +1 and -1. Each impulse is followed by 127 zeros. The second part is a run of 128 symbols at +2 and then a run of 128 symbols at -2. The third part is a silent tail of 1024 zeros. The sequence then starts again with the +2 impulse and repeats for as long as the enable input stays high.

When enable drops, all lanes return to zero and the position in the period is discarded. The next enable starts again from the first impulse. A valid flag marks the cycles in which the pattern is live. A one-cycle marker shows where each period begins.

Top module: `gpam_testpat`

## Requirements
- R1: During and directly after a synchronous reset, every lane reads zero and both the valid flag and the period marker are low.
- R2: The output register stage adds one clock of latency. The valid flag is high in the cycle after a clock edge at which enable is sampled high and reset is low. It is low in the cycle after an edge at which enable is sampled low.
- R3: Each lane carries a 3-bit two's-complement symbol, and lane k occupies bits [3k+2:3k]. The codes are: +2 is 010, +1 is 001, 0 is 000, -1 is 111 and -2 is 110. No other code is ever produced.
- R4: Within a period, symbol indices 0, 128, 256 and 384 carry +2, -2, +1 and -1 respectively. Every other index below 512 carries zero.
- R5: Indices 512 to 639 all carry +2, and indices 640 to 767 all carry -2.
- R6: Indices 768 to 1791 carry zero. The symbol after index 1791 is index 0 of the next period, so the pattern repeats every 1792 symbols without a gap.
- R7: All four lanes carry the same symbol in every cycle.
- R8: The period marker is high for exactly one cycle, in the cycle in which index 0 is on the lanes.
- R9: While enable is low, all lanes read zero and the valid flag is low. The first valid symbol after enable returns is index 0, with the period marker set.
- R10: Reset takes priority over enable. A reset issued in the middle of a period returns the outputs to idle, and the sequence restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Pattern enable, active high |
| lane_sym | output | 12 | Four 3-bit signed symbols; lane k occupies bits [3k+2:3k] |
| sym_valid | output | 1 | High while the lanes carry pattern symbols |
| period_start | output | 1 | One-cycle pulse that accompanies index 0 |

## Verification
Two events can fall in the same cycle. One is the natural wrap from index 1791 back to index 0. The other is a restart, when enable returns or reset is released. Both must raise the period marker together with the +2 impulse, and neither may shift the index. The bench runs the pattern across several natural wraps, then cuts bursts of random length so that a restart lands at arbitrary positions, including just before and just after a wrap. It also applies reset while enable stays high. In every cycle, a reference model kept in the bench judges the symbol on each lane, the valid flag and the marker.

// File: rtl/gpam_testpat.sv
module gpam_testpat #(
  parameter int LANES    = 4,
  parameter int SYM_W    = 3,
  parameter int GAP_LEN  = 127,
  parameter int RUN_LEN  = 128,
  parameter int TAIL_LEN = 1024
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  output logic [LANES*SYM_W-1:0] lane_sym,
  output logic                   sym_valid,
  output logic                   period_start
);
  localparam int SLOT    = GAP_LEN + 1;
  localparam int IMP_END = 4 * SLOT;
  localparam int POS_END = IMP_END + RUN_LEN;
  localparam int NEG_END = POS_END + RUN_LEN;
  localparam int PERIOD  = NEG_END + TAIL_LEN;
  localparam int IDX_W   = $clog2(PERIOD);

  typedef logic signed [SYM_W-1:0] sym_t;
  localparam sym_t P2 = sym_t'(2);
  localparam sym_t P1 = sym_t'(1);
  localparam sym_t N1 = sym_t'(-1);
  localparam sym_t N2 = sym_t'(-2);
  localparam sym_t Z0 = sym_t'(0);

  logic [IDX_W-1:0] idx;
  sym_t             nxt;
  sym_t             lane_q [LANES];
  logic             live;

  assign live = en && !rst;

  always_comb begin
    int pos;
    pos = int'(idx);
    nxt = Z0;
    if (pos < IMP_END) begin
      if (pos % SLOT == 0) begin
        case (pos / SLOT)
          0:       nxt = P2;
          1:       nxt = N2;
          2:       nxt = P1;
          default: nxt = N1;
        endcase
      end
    end else if (pos < POS_END) begin
      nxt = P2;
    end else if (pos < NEG_END) begin
      nxt = N2;
    end
  end

  always_ff @(posedge clk) begin
    if (!live) begin
      idx          <= '0;
      sym_valid    <= 1'b0;
      period_start <= 1'b0;
      for (int k = 0; k < LANES; k++) lane_q[k] <= Z0;
    end else begin
      idx          <= (int'(idx) == PERIOD - 1) ? '0 : idx + 1'b1;
      sym_valid    <= 1'b1;
      period_start <= (idx == '0);
      for (int k = 0; k < LANES; k++) lane_q[k] <= nxt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sym[g*SYM_W +: SYM_W] = lane_q[g];
  end

  // R2
  valid_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> sym_valid);
  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sym_valid);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |-> (lane_sym == '0));
  // R8
  start_level_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (sym_valid && lane_q[0] == P2));
  // R9
  restart_marker_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !$past(sym_valid)) |-> period_start);
  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (lane_q[0] >= N2 && lane_q[0] <= P2));
  // R8
  single_marker_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);
endmodule

// File: tb/gpam_testpat_bench.sv
`timescale 1ns/1ps
module gpam_testpat_bench;
  localparam int PER = 1792;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [11:0] lane_sym;
  logic        sym_valid;
  logic        period_start;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int m_idx = 0;
  int m_cur = 0;
  int m_sym = 0;
  bit m_valid = 0;
  bit m_start = 0;
  bit m_prev_valid = 0;
  bit in_init = 1;

  always #5 clk = ~clk;

  gpam_testpat u_gpam_testpat (
    .clk(clk), .rst(rst), .en(en),
    .lane_sym(lane_sym), .sym_valid(sym_valid), .period_start(period_start)
  );

  function automatic int exp_level(int i);
    if (i < 512) begin
      if (i % 128 != 0) return 0;
      case (i / 128)
        0: return 2;
        1: return -2;
        2: return 1;
        default: return -1;
      endcase
    end
    if (i < 640) return 2;
    if (i < 768) return -2;
    return 0;
  endfunction

  function automatic int lane_val(int k);
    logic signed [2:0] v;
    v = lane_sym[k*3 +: 3];
    return int'(v);
  endfunction

  function automatic string region_tag(int i);
    if (i < 512) return "R4";
    if (i < 768) return "R5";
    return "R6";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit e, bit r);
    string tag;
    logic [2:0] code;
    en = e;
    rst = r;
    @(posedge clk);
    m_prev_valid = m_valid;
    if (r || !e) begin
      m_valid = 0; m_start = 0; m_sym = 0; m_idx = 0;
    end else begin
      m_cur = m_idx;
      m_sym = exp_level(m_idx);
      m_start = (m_idx == 0);
      m_valid = 1;
      m_idx = (m_idx + 1) % PER;
    end
    @(negedge clk);
    if (r) tag = in_init ? "R1" : "R10";
    else if (!e) tag = "R9";
    else tag = region_tag(m_cur);
    chk(lane_val(0) == m_sym, tag, lane_val(0), m_sym);
    for (int k = 1; k < 4; k++)
      chk(lane_val(k) == lane_val(0), "R7", lane_val(k), lane_val(0));
    chk(sym_valid == m_valid, r ? tag : "R2", int'(sym_valid), int'(m_valid));
    chk(period_start == m_start, r ? tag : "R8", int'(period_start), int'(m_start));
    if (m_valid && !m_prev_valid)
      chk(period_start == 1'b1, "R9", int'(period_start), 1);
    if (m_valid && (m_cur == 0 || m_cur == 128 || m_cur == 256 || m_cur == 384 || m_cur == 768)) begin
      case (m_cur)
        0:   code = 3'b010;
        128: code = 3'b110;
        256: code = 3'b001;
        384: code = 3'b111;
        default: code = 3'b000;
      endcase
      chk(lane_sym[((m_cur/128)%4)*3 +: 3] == code, "R3",
          int'(lane_sym[((m_cur/128)%4)*3 +: 3]), int'(code));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int len;
    seed = $urandom(32'd4242);
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    in_init = 0;
    for (int i = 0; i < 3 * PER + 10; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
    for (int i = 0; i < PER - 201; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    for (int b = 0; b < 30; b++) begin
      len = 1 + int'($urandom % 2000);
      for (int i = 0; i < len; i++)
        step(1'b1, ($urandom % 700) == 0);
      len = 1 + int'($urandom % 8);
      for (int i = 0; i < len; i++) step(1'b0, ($urandom % 4) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule